// File: doc/BRIEF.md
# ADC Register Sequencer

This block is the register front end of a multi-channel successive-approximation converter. Software reaches it over a plain register bus: address, write strobe, write data and a read-data return. Software picks one of 32 channels and one of four input scales. It sets a repeat count, switches the converter on and issues a run command. The block then carries out a request/done handshake with the converter for each sample. It keeps the most recent 12-bit result and reports the end of the run through an interrupt register group.

A small state machine handles the handshake. It has three states: `SQ_IDLE`, `SQ_CONV` and `SQ_GAP`.

- `SQ_CONV` raises the conversion request and holds it.
- `SQ_GAP` drops the request for one cycle between samples, so each sample is a separate request.

The transitions are:

- *start*: IDLE to CONV, taken on a run command while the converter is enabled.
- *next*: CONV to GAP, taken on a done strobe when more samples remain.
- *resume*: GAP to CONV.
- *finish*: CONV to IDLE, taken on the done strobe of the last sample.
- *abort*: CONV or GAP to IDLE, taken whenever the enable bit is found clear.

Completion sets a raw flag. Software can poll the raw flag, or route it to the interrupt line through an enable bit.

Top module: `adcseq_top`

## Requirements
- R1: After reset every readable register returns 0, `irq` is low and `conv_req` is low.
- R2: Register map and config fields:
  - Offset 0x00 is the control register: converter enable at bit 0, run at bit 1, 12-bit mode at bit 2, run count at bits 7:4. Bit 1 reads back as 1 only while a run is in progress.
  - Offset 0x04 is the config register: channel at bits 4:0, scale at bits 10:9. Its other bits read as 0.
  - The channel and scale fields drive `conv_chan` and `conv_scale`. The 12-bit mode bit drives `conv_wide`.
- R3: A control write with the run bit set and the enable bit 0 starts nothing. No request is raised and bit 1 reads 0.
- R4: A run started with count N raises `conv_req` N+1 separate times, with `conv_req` low for at least one cycle between samples. A count of 0 yields exactly one sample.
- R5: The data register at 0x4C returns the last completed sample in bits 11:0, with bits 31:12 reading 0. It changes only when a sample completes.
- R6: Raw status bit 0 at 0x5C becomes 1 after the final sample of a run, whatever the interrupt enable holds. The run bit clears at the same time.
- R7: Masked status bit 0 at 0x58 equals raw bit 0 AND interrupt-enable bit 0 at 0x50. `irq` equals the masked status bit.
- R8: Writing bit 0 = 1 at 0x54 clears the raw flag. Writing bit 0 = 0 there leaves it unchanged. 0x54 reads as 0.
- R9: When a clear write and the completion of the final sample fall in the same cycle, the raw flag ends up set.
- R10: Clearing the enable bit during a run returns the block to idle. Neither the sample in flight nor any later sample is taken, the data register keeps its value and the raw flag is not set.
- R11: A run command written while a run is in progress neither restarts the run nor changes the number of samples it takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 5 | Selected channel |
| conv_scale | output | 2 | Selected input scale |
| conv_wide | output | 1 | 12-bit mode select |
| conv_done | input | 1 | One-cycle strobe, the converter result is valid |
| conv_result | input | 12 | Converter result |
| irq | output | 1 | Interrupt, masked status |

## Verification
Randomized runs vary the channel, the scale, the repeat count from 0 to 3, the interrupt enable and the converter latency from 0 to 4 cycles. Comparing request pulses and done strobes against the count separates a correct sample count from an off-by-one, and separates a missing gap from a proper one. The interrupt-enable variation shows whether the raw flag is truly independent of masking. Directed cases target the orderings that random stimulus rarely reaches:
- a run command with the converter disabled;
- a second run command during a run;
- disabling the converter partway through a slow conversion, where the data register must keep its earlier value;
- a clear write that lands on the very edge where the last done strobe is sampled, where the flag must survive.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
    // register byte offsets
    localparam int unsigned OFF_CTL  = 32'h00;
    localparam int unsigned OFF_CFG  = 32'h04;
    localparam int unsigned OFF_DATA = 32'h4C;
    localparam int unsigned OFF_IEN  = 32'h50;
    localparam int unsigned OFF_ICLR = 32'h54;
    localparam int unsigned OFF_ISTS = 32'h58;
    localparam int unsigned OFF_IRAW = 32'h5C;

    // control and config field positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_RUN_BIT   = 1;
    localparam int CTL_WIDE_BIT  = 2;
    localparam int CTL_CNT_LSB   = 4;
    localparam int CFG_SCALE_LSB = 9;
    localparam int IRQ_BIT       = 0;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CONV = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adcseq_fsm.sv
`timescale 1ns/1ps
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             conv_done,
    output logic             conv_req,
    output logic             busy,
    output logic             sample_ok,
    output logic             last_ok
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d = SQ_CONV;          // start
                    left_d  = start_cnt;
                end
            end
            SQ_CONV: begin
                if (!enable) begin
                    state_d = SQ_IDLE;          // abort
                end else if (conv_done) begin
                    if (left_q == '0) begin
                        state_d = SQ_IDLE;      // finish
                    end else begin
                        state_d = SQ_GAP;       // next
                        left_d  = left_q - 1'b1;
                    end
                end
            end
            SQ_GAP: begin
                if (!enable) state_d = SQ_IDLE; // abort
                else         state_d = SQ_CONV; // resume
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // outputs
    always_comb begin
        conv_req  = (state_q == SQ_CONV);
        busy      = (state_q != SQ_IDLE);
        sample_ok = (state_q == SQ_CONV) && enable && conv_done;
        last_ok   = sample_ok && (left_q == '0);
    end

    a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !enable) |=> !busy);
    a_r4_gap_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_ok && !last_ok) |=> !conv_req);
    a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_ok |=> !busy);
endmodule

// File: rtl/adcseq_regs.sv
`timescale 1ns/1ps
module adcseq_regs
    import adcseq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CH_W    = 5,
    parameter int SCALE_W = 2,
    parameter int CNT_W   = 4,
    parameter int RES_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               busy,
    input  logic               sample_ok,
    input  logic               last_ok,
    input  logic [RES_W-1:0]   conv_result,
    output logic               enable,
    output logic               start,
    output logic [CNT_W-1:0]   start_cnt,
    output logic [CH_W-1:0]    cfg_chan,
    output logic [SCALE_W-1:0] cfg_scale,
    output logic               wide,
    output logic               irq
);
    logic             en_q, wide_q, ien_q, raw_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RES_W-1:0] data_q;
    logic             wr_ctl, wr_cfg, wr_ien, wr_clr;
    logic             stat;

    assign wr_ctl = bus_we && (bus_addr == ADDR_W'(OFF_CTL));
    assign wr_cfg = bus_we && (bus_addr == ADDR_W'(OFF_CFG));
    assign wr_ien = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
    assign wr_clr = bus_we && (bus_addr == ADDR_W'(OFF_ICLR));

    assign start     = wr_ctl && bus_wdata[CTL_EN_BIT] && bus_wdata[CTL_RUN_BIT] && !busy;
    assign start_cnt = bus_wdata[CTL_CNT_LSB +: CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            wide_q    <= 1'b0;
            cnt_q     <= '0;
            cfg_chan  <= '0;
            cfg_scale <= '0;
            ien_q     <= 1'b0;
            data_q    <= '0;
            raw_q     <= 1'b0;
        end else begin
            if (wr_ctl) begin
                en_q   <= bus_wdata[CTL_EN_BIT];
                wide_q <= bus_wdata[CTL_WIDE_BIT];
                cnt_q  <= bus_wdata[CTL_CNT_LSB +: CNT_W];
            end
            if (wr_cfg) begin
                cfg_chan  <= bus_wdata[CH_W-1:0];
                cfg_scale <= bus_wdata[CFG_SCALE_LSB +: SCALE_W];
            end
            if (wr_ien) ien_q <= bus_wdata[IRQ_BIT];
            if (sample_ok) data_q <= conv_result;
            // completion takes priority over a clear in the same cycle
            if (last_ok)                          raw_q <= 1'b1;
            else if (wr_clr && bus_wdata[IRQ_BIT]) raw_q <= 1'b0;
        end
    end

    assign enable = en_q;
    assign wide   = wide_q;
    assign stat   = raw_q & ien_q;
    assign irq    = stat;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTL)) begin
            bus_rdata[CTL_EN_BIT]               = en_q;
            bus_rdata[CTL_RUN_BIT]              = busy;
            bus_rdata[CTL_WIDE_BIT]             = wide_q;
            bus_rdata[CTL_CNT_LSB +: CNT_W]     = cnt_q;
        end else if (bus_addr == ADDR_W'(OFF_CFG)) begin
            bus_rdata[CH_W-1:0]                 = cfg_chan;
            bus_rdata[CFG_SCALE_LSB +: SCALE_W] = cfg_scale;
        end else if (bus_addr == ADDR_W'(OFF_DATA)) begin
            bus_rdata[RES_W-1:0]                = data_q;
        end else if (bus_addr == ADDR_W'(OFF_IEN)) begin
            bus_rdata[IRQ_BIT]                  = ien_q;
        end else if (bus_addr == ADDR_W'(OFF_ISTS)) begin
            bus_rdata[IRQ_BIT]                  = stat;
        end else if (bus_addr == ADDR_W'(OFF_IRAW)) begin
            bus_rdata[IRQ_BIT]                  = raw_q;
        end
    end

    a_r9_completion_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        last_ok |=> raw_q);
    a_r5_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_ok |=> $stable(data_q));
    a_r8_clear_drops_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[IRQ_BIT] && !last_ok) |=> !raw_q);
    a_r6_raw_rises_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(last_ok));
endmodule

// File: rtl/adcseq_top.sv
`timescale 1ns/1ps
module adcseq_top #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CH_W    = 5,
    parameter int SCALE_W = 2,
    parameter int CNT_W   = 4,
    parameter int RES_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               conv_req,
    output logic [CH_W-1:0]    conv_chan,
    output logic [SCALE_W-1:0] conv_scale,
    output logic               conv_wide,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_result,
    output logic               irq
);
    logic             enable, start, busy, sample_ok, last_ok;
    logic [CNT_W-1:0] start_cnt;

    adcseq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W),
        .SCALE_W(SCALE_W), .CNT_W(CNT_W), .RES_W(RES_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .sample_ok(sample_ok), .last_ok(last_ok), .conv_result(conv_result),
        .enable(enable), .start(start), .start_cnt(start_cnt),
        .cfg_chan(conv_chan), .cfg_scale(conv_scale), .wide(conv_wide), .irq(irq)
    );

    adcseq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .enable(enable), .start(start), .start_cnt(start_cnt), .conv_done(conv_done),
        .conv_req(conv_req), .busy(busy), .sample_ok(sample_ok), .last_ok(last_ok)
    );
endmodule

// File: tb/tb_adcseq_top.sv
`timescale 1ns/1ps
module tb_adcseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_req, conv_wide, irq;
    logic [4:0]  conv_chan;
    logic [1:0]  conv_scale;
    logic        conv_done;
    logic [11:0] conv_result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // converter model state
    int          lat_force = -1;
    int          wait_cnt;
    int          dones = 0;
    int          rises = 0;
    int          chan_bad = 0;
    logic        req_prev;
    logic [11:0] last_res;
    logic [4:0]  exp_chan = '0;
    logic [1:0]  exp_scale = '0;

    always #2 clk = ~clk;

    adcseq_top dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_scale(conv_scale), .conv_wide(conv_wide),
        .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
    );

    function automatic int pick_lat(int force_v);
        return (force_v >= 0) ? force_v : int'($urandom % 5);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_done   <= 1'b0;
            conv_result <= '0;
            wait_cnt    <= 0;
            req_prev    <= 1'b0;
            last_res    <= '0;
        end else begin
            req_prev <= conv_req;
            if (conv_req && !req_prev) rises <= rises + 1;
            if (conv_req && !conv_done) begin
                if (wait_cnt == 0) begin
                    logic [11:0] r;
                    r = 12'($urandom);
                    conv_done   <= 1'b1;
                    conv_result <= r;
                    last_res    <= r;
                    dones       <= dones + 1;
                    if (conv_chan != exp_chan || conv_scale != exp_scale) chan_bad <= chan_bad + 1;
                    wait_cnt    <= pick_lat(lat_force);
                end else begin
                    wait_cnt <= wait_cnt - 1;
                end
            end else begin
                conv_done <= 1'b0;
                if (!conv_req) wait_cnt <= pick_lat(lat_force);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(8'h00, v);
            if (!v[1]) break;
        end
    endtask

    function automatic logic [31:0] exp_cfg(input logic [31:0] w);
        return {21'd0, w[10:9], 4'd0, w[4:0]};
    endfunction

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R6: actual 0 expected 1 (run never finished)");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, d0, w;
        int d_snap, r_snap;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_chk(8'h00, 0, "R1 ctl"); rd_chk(8'h04, 0, "R1 cfg");
        rd_chk(8'h4C, 0, "R1 data"); rd_chk(8'h50, 0, "R1 ien");
        rd_chk(8'h58, 0, "R1 sts"); rd_chk(8'h5C, 0, "R1 raw");
        check(irq == 0 && conv_req == 0, "R1 irq/req", {irq, conv_req}, 0);

        // R2 field masking, R3 run while disabled
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h0000_061F, "R2 cfg mask");
        check(conv_chan == 5'h1F && conv_scale == 2'd3, "R2 cfg outputs", {conv_scale, conv_chan}, 7'h7F);
        r_snap = rises;
        wr(8'h00, 32'hFFFF_FFF6);
        repeat (10) @(negedge clk);
        rd_chk(8'h00, 32'h0000_00F4, "R3 run bit with enable 0");
        check(rises == r_snap, "R3 no request", rises - r_snap, 0);
        check(conv_wide == 1, "R2 wide output", conv_wide, 1);
        rd_chk(8'h54, 0, "R8 clear reads 0");

        // random runs: R2 R4 R5 R6 R7 R8
        for (int it = 0; it < 16; it++) begin
            int cnt, ie;
            cnt = int'($urandom % 4);
            ie  = int'($urandom % 2);
            w   = {21'd0, 2'($urandom), 4'd0, 5'($urandom)};
            exp_chan = w[4:0]; exp_scale = w[10:9];
            lat_force = -1;
            wr(8'h50, 32'(ie));
            wr(8'h04, w);
            wr(8'h54, 32'h1);
            d_snap = dones; r_snap = rises;
            wr(8'h00, 32'(cnt << 4) | 32'h7);
            wait_idle();
            check(dones - d_snap == cnt + 1, "R4 sample count", dones - d_snap, cnt + 1);
            check(rises - r_snap == cnt + 1, "R4 separate requests", rises - r_snap, cnt + 1);
            check(chan_bad == 0, "R2 channel/scale at converter", chan_bad, 0);
            rd_chk(8'h4C, {20'd0, last_res}, "R5 data");
            rd_chk(8'h5C, 1, "R6 raw set");
            rd_chk(8'h58, 32'(ie), "R7 masked status");
            check(irq == ie[0], "R7 irq", irq, ie);
            wr(8'h54, 32'h0);
            rd_chk(8'h5C, 1, "R8 clear write 0 keeps raw");
            wr(8'h54, 32'h1);
            rd_chk(8'h5C, 0, "R8 clear");
            check(irq == 0, "R7 irq after clear", irq, 0);
        end

        // R11 run command while busy
        exp_chan = w[4:0]; exp_scale = w[10:9];
        lat_force = 10;
        d_snap = dones; r_snap = rises;
        wr(8'h00, 32'h03);
        repeat (2) @(negedge clk);
        wr(8'h00, 32'h33);
        wait_idle();
        check(dones - d_snap == 1, "R11 no restart", dones - d_snap, 1);
        check(rises - r_snap == 1, "R11 single request", rises - r_snap, 1);
        wr(8'h54, 32'h1);

        // R10 abort mid-run
        lat_force = 30;
        rd(8'h4C, d0);
        d_snap = dones;
        wr(8'h00, 32'h23);
        repeat (5) @(negedge clk);
        wr(8'h00, 32'h0);
        repeat (40) @(negedge clk);
        rd_chk(8'h4C, d0, "R10 data unchanged");
        rd_chk(8'h5C, 0, "R10 raw not set");
        rd_chk(8'h00, 0, "R10 idle after abort");
        check(dones == d_snap && conv_req == 0, "R10 no sample", dones - d_snap, 0);

        // R9 clear coincides with completion
        lat_force = 3;
        wr(8'h00, 32'h03);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (conv_done) break;
        end
        bus_addr = 8'h54; bus_we = 1'b1; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk(8'h5C, 1, "R9 completion beats clear");
        rd_chk(8'h4C, {20'd0, last_res}, "R5 data after collision run");

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule